// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the software-visible configuration of an SDRAM controller. Two bus ports reach it. The select port holds a 32-bit internal offset, and the data port reads or writes the register that this offset selects. Behind that window are the following registers:

- two error-status words, which software clears by writing ones and hardware sets through strobe inputs;
- an error-address word;
- a configuration word, and a read-only status word derived from it;
- a refresh timer, a power-management timer and a timing word;
- an ECC configuration word and an ECC error word;
- a parameterised set of bank-configuration words.

Each register stores only the bits its write mask allows, and some registers force bits to one. The block drives the masked control words and the controller enable flag on its outputs. It also drives an ECC interrupt, which is high whenever the ECC error word is nonzero.

The block also decodes a physical address against the bank words. Each bank word gives a base, a size code and a valid bit. One cycle after an address is presented, the block reports whether a bank holds that address and which bank it is. When banks overlap, the lowest-numbered bank is reported.

Top module: `sdram_cfg_regs`

## Requirements
- R1: Bus port 0x10 reads and writes the 32-bit offset register. Bus port 0x11 reads and writes the register that the offset selects. Read data appears on `bus_rdata` on the cycle after `bus_re` and holds until the next read. A read of any other port returns zero. A write to any other port changes nothing.
- R2: The internal offsets are as follows. Error status A is 0x00, error status B is 0x08 and error address is 0x10. Configuration is 0x20 and status is 0x24. Refresh timer is 0x30 and power timer is 0x34. Bank word i is at 0x40+4*i. Timing is 0x80, ECC configuration is 0x94 and ECC error is 0x98. The error-address and ECC-error words store all 32 written bits.
- R3: After reset the registers hold the following values. Power timer is 0x07C00000, refresh timer is 0x05F00000, timing is 0x00854009 and configuration is 0x00800000. Every other register, including the offset register, is 0.
- R4: A write to either error-status word clears the bits written as one. A bit whose `err_set` strobe is high in the same cycle is set, and the set takes priority over the clear.
- R5: The status word is read-only. Configuration bit 31 going 0→1 clears status bit 31, and 1→0 sets it. Status bit 30 takes the value of the written configuration bit 30. All other status bits read 0.
- R6: Write masks apply to stored values. The refresh timer keeps the bits of 0x3FF80000, timing keeps 0x018FC01F, ECC configuration keeps 0x00F00000 and bank words keep 0xFFDEE001. The power timer stores the written value AND 0xF8000000, OR 0x07C00000.
- R7: `ecc_irq` is 1 exactly when the ECC error word is nonzero. It rises on the cycle after a write that makes the word nonzero, and it falls after a write of zero.
- R8: An offset that is not listed in R2 reads 0, and a write to it has no effect.
- R9: A bank covers the window [base, base + 4 MiB × 2^code). The base is its bits 31:23 with the low bits zero. The code is its bits 19:17.
- R10: A bank hit needs three things: configuration bit 31 set, the bank's bit 0 (valid) set, and the address inside the bank's window. Among the banks that hit, the lowest-numbered one wins. With no hit, `bank_idx` is 0. Both `bank_hit` and `bank_idx` reflect the address presented one clock earlier.
- R11: `ctrl_enable` equals configuration bit 31. The cfg, refresh, timing, power and ECC-config output words equal the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Bus port number |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_set_a | input | 32 | Hardware set strobes for error status A |
| err_set_b | input | 32 | Hardware set strobes for error status B |
| phys_addr | input | 32 | Physical address to decode |
| bank_hit | output | 1 | Address falls in an enabled, valid bank |
| bank_idx | output | 2 | Index of the winning bank |
| ctrl_enable | output | 1 | Controller enable (configuration bit 31) |
| ecc_irq | output | 1 | ECC error interrupt |
| cfg_word | output | 32 | Configuration register |
| refresh_word | output | 32 | Refresh timer register |
| timing_word | output | 32 | Timing register |
| power_word | output | 32 | Power-management timer register |
| ecc_cfg_word | output | 32 | ECC configuration register |

## Verification
Overlapping bank windows are the hardest case to reach from the ports. The priority rule only shows when an enabled, valid low-numbered bank and a higher-numbered bank both cover an address. It changes again when the low bank is later invalidated. The bench programs four banks with different size codes, two of them overlapping. It then sweeps the address in 1 MiB steps and probes the addresses one below each window start, one below each window end and exactly at each window end. It repeats the sweep with the controller disabled and again after invalidating the overlapping low bank. Expected hits are computed arithmetically from the bank words as written.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

  localparam int unsigned DW = 32;

  // internal offsets
  localparam logic [DW-1:0] OFS_ERR_A   = 32'h00;
  localparam logic [DW-1:0] OFS_ERR_B   = 32'h08;
  localparam logic [DW-1:0] OFS_ERR_ADR = 32'h10;
  localparam logic [DW-1:0] OFS_CFG     = 32'h20;
  localparam logic [DW-1:0] OFS_STAT    = 32'h24;
  localparam logic [DW-1:0] OFS_REFR    = 32'h30;
  localparam logic [DW-1:0] OFS_PWR     = 32'h34;
  localparam logic [DW-1:0] OFS_BANK0   = 32'h40;
  localparam logic [DW-1:0] OFS_TIME    = 32'h80;
  localparam logic [DW-1:0] OFS_ECC_CFG = 32'h94;
  localparam logic [DW-1:0] OFS_ECC_ERR = 32'h98;

  // write masks and forced bits
  localparam logic [DW-1:0] MSK_REFR    = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_TIME    = 32'h018F_C01F;
  localparam logic [DW-1:0] MSK_ECC_CFG = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_BANK    = 32'hFFDE_E001;
  localparam logic [DW-1:0] MSK_PWR     = 32'hF800_0000;
  localparam logic [DW-1:0] FRC_PWR     = 32'h07C0_0000;

  // reset values
  localparam logic [DW-1:0] RST_PWR  = 32'h07C0_0000;
  localparam logic [DW-1:0] RST_REFR = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_TIME = 32'h0085_4009;
  localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;

  // bank word fields
  localparam logic [DW-1:0] BANK_BASE_MSK = 32'hFF80_0000;
  localparam int unsigned   BANK_CODE_LSB = 17;
  localparam int unsigned   BANK_CODE_W   = 3;
  localparam logic [DW:0]   BANK_MIN_SPAN = 33'h0_0040_0000;

  function automatic logic [DW:0] bank_span(input logic [BANK_CODE_W-1:0] code);
    return BANK_MIN_SPAN << code;
  endfunction

endpackage

// File: rtl/sdram_cfg_file.sv
module sdram_cfg_file
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NBANK = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DW-1:0]       sel_ofs,
  input  logic [DW-1:0]       wdata,
  input  logic [DW-1:0]       err_set_a,
  input  logic [DW-1:0]       err_set_b,
  output logic [DW-1:0]       rdata,
  output logic [DW-1:0]       cfg_q,
  output logic [DW-1:0]       refr_q,
  output logic [DW-1:0]       time_q,
  output logic [DW-1:0]       pwr_q,
  output logic [DW-1:0]       ecc_cfg_q,
  output logic                ecc_irq,
  output logic [NBANK*DW-1:0] bank_flat
);

  logic [DW-1:0] err_a_q, err_b_q, err_adr_q, ecc_err_q;
  logic [1:0]    stat_q;   // status bits 31:30
  logic [DW-1:0] bank_q [NBANK];

  logic hit_err_a, hit_err_b, hit_err_adr, hit_cfg, hit_stat, hit_refr;
  logic hit_pwr, hit_time, hit_ecc_cfg, hit_ecc_err;

  assign hit_err_a   = wr_en && (sel_ofs == OFS_ERR_A);
  assign hit_err_b   = wr_en && (sel_ofs == OFS_ERR_B);
  assign hit_err_adr = wr_en && (sel_ofs == OFS_ERR_ADR);
  assign hit_cfg     = wr_en && (sel_ofs == OFS_CFG);
  assign hit_stat    = wr_en && (sel_ofs == OFS_STAT);
  assign hit_refr    = wr_en && (sel_ofs == OFS_REFR);
  assign hit_pwr     = wr_en && (sel_ofs == OFS_PWR);
  assign hit_time    = wr_en && (sel_ofs == OFS_TIME);
  assign hit_ecc_cfg = wr_en && (sel_ofs == OFS_ECC_CFG);
  assign hit_ecc_err = wr_en && (sel_ofs == OFS_ECC_ERR);

  // error status: write-one-to-clear, hardware set wins
  always_ff @(posedge clk) begin
    if (rst) begin
      err_a_q <= '0;
      err_b_q <= '0;
    end else begin
      err_a_q <= (hit_err_a ? (err_a_q & ~wdata) : err_a_q) | err_set_a;
      err_b_q <= (hit_err_b ? (err_b_q & ~wdata) : err_b_q) | err_set_b;
    end
  end

  // configuration and derived status
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= RST_CFG;
      stat_q <= 2'b00;
    end else if (hit_cfg) begin
      cfg_q <= wdata;
      if (!cfg_q[31] && wdata[31])      stat_q[1] <= 1'b0;
      else if (cfg_q[31] && !wdata[31]) stat_q[1] <= 1'b1;
      stat_q[0] <= wdata[30];
    end
  end

  // plain masked registers
  always_ff @(posedge clk) begin
    if (rst) begin
      err_adr_q <= '0;
      refr_q    <= RST_REFR;
      pwr_q     <= RST_PWR;
      time_q    <= RST_TIME;
      ecc_cfg_q <= '0;
      ecc_err_q <= '0;
    end else begin
      if (hit_err_adr) err_adr_q <= wdata;
      if (hit_refr)    refr_q    <= wdata & MSK_REFR;
      if (hit_pwr)     pwr_q     <= (wdata & MSK_PWR) | FRC_PWR;
      if (hit_time)    time_q    <= wdata & MSK_TIME;
      if (hit_ecc_cfg) ecc_cfg_q <= wdata & MSK_ECC_CFG;
      if (hit_ecc_err) ecc_err_q <= wdata;
    end
  end

  assign ecc_irq = |ecc_err_q;

  // bank words
  for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
    localparam logic [DW-1:0] BOFS = OFS_BANK0 + DW'(4 * gi);
    always_ff @(posedge clk) begin
      if (rst)                             bank_q[gi] <= '0;
      else if (wr_en && sel_ofs == BOFS)   bank_q[gi] <= wdata & MSK_BANK;
    end
    assign bank_flat[gi*DW +: DW] = bank_q[gi];
  end

  // read mux
  always_comb begin
    rdata = '0;
    unique case (sel_ofs)
      OFS_ERR_A:   rdata = err_a_q;
      OFS_ERR_B:   rdata = err_b_q;
      OFS_ERR_ADR: rdata = err_adr_q;
      OFS_CFG:     rdata = cfg_q;
      OFS_STAT:    rdata = {stat_q, 30'd0};
      OFS_REFR:    rdata = refr_q;
      OFS_PWR:     rdata = pwr_q;
      OFS_TIME:    rdata = time_q;
      OFS_ECC_CFG: rdata = ecc_cfg_q;
      OFS_ECC_ERR: rdata = ecc_err_q;
      default:     rdata = '0;
    endcase
    for (int i = 0; i < NBANK; i++) begin
      if (sel_ofs == OFS_BANK0 + DW'(4 * i)) rdata = bank_q[i];
    end
  end

  // R4: bits written as one are clear afterwards unless set by hardware
  p_w1c_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (hit_err_a && err_set_a == '0) |=> ((err_a_q & $past(wdata)) == '0));

  // R5: status does not change on a write to its own offset
  p_status_ro_r5: assert property (@(posedge clk) disable iff (rst)
    hit_stat |=> $stable(stat_q));

  // R5: enabling clears not-ready, disabling sets it
  p_enable_ready_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_q[31]) |-> !stat_q[1]);
  p_disable_ready_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_q[31]) |-> stat_q[1]);

  // R6: forced power-timer bits stay set
  p_pwr_forced_r6: assert property (@(posedge clk) disable iff (rst)
    pwr_q[26:22] == 5'h1F);

  // R7: a nonzero write to the ECC error word raises the interrupt
  p_ecc_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (hit_ecc_err && wdata != '0) |=> ecc_irq);
  p_ecc_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (hit_ecc_err && wdata == '0) |=> !ecc_irq);

endmodule

// File: rtl/sdram_cfg_bank_dec.sv
module sdram_cfg_bank_dec
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  localparam int unsigned IW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [NBANK*DW-1:0] bank_flat,
  input  logic [DW-1:0]       phys_addr,
  output logic                hit_q,
  output logic [IW-1:0]       idx_q
);

  logic [NBANK-1:0] in_win;
  logic [NBANK-1:0] win_pri;

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_win
    logic [DW-1:0] word;
    logic [DW:0]   base, top, addr_x;
    assign word   = bank_flat[gi*DW +: DW];
    assign base   = {1'b0, word & BANK_BASE_MSK};
    assign top    = base + bank_span(word[BANK_CODE_LSB +: BANK_CODE_W]);
    assign addr_x = {1'b0, phys_addr};
    assign in_win[gi] = enable && word[0] && (addr_x >= base) && (addr_x < top);
  end

  // lowest-numbered bank wins
  always_comb begin
    win_pri = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (in_win[i]) win_pri = NBANK'(1) << i;
    end
  end

  logic [IW-1:0] idx_d;
  always_comb begin
    idx_d = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (win_pri[i]) idx_d = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= |win_pri;
      idx_q <= idx_d;
    end
  end

  // R10: at most one bank is selected after priority
  p_one_bank_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_pri));

  // R10: no hit while the controller is disabled
  p_disabled_nohit_r10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !hit_q);

endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned PORT_AW   = 10,
  parameter int unsigned OFS_PORT  = 16,
  parameter int unsigned DATA_PORT = 17,
  parameter int unsigned NBANK     = 4,
  localparam int unsigned IW       = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PORT_AW-1:0] bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [DW-1:0]      err_set_a,
  input  logic [DW-1:0]      err_set_b,
  input  logic [DW-1:0]      phys_addr,
  output logic               bank_hit,
  output logic [IW-1:0]      bank_idx,
  output logic               ctrl_enable,
  output logic               ecc_irq,
  output logic [DW-1:0]      cfg_word,
  output logic [DW-1:0]      refresh_word,
  output logic [DW-1:0]      timing_word,
  output logic [DW-1:0]      power_word,
  output logic [DW-1:0]      ecc_cfg_word
);

  localparam logic [PORT_AW-1:0] P_OFS  = PORT_AW'(OFS_PORT);
  localparam logic [PORT_AW-1:0] P_DATA = PORT_AW'(DATA_PORT);

  logic                ofs_sel, data_sel;
  logic [DW-1:0]       ofs_q;
  logic [DW-1:0]       file_rdata;
  logic [NBANK*DW-1:0] bank_flat;

  assign ofs_sel  = (bus_addr == P_OFS);
  assign data_sel = (bus_addr == P_DATA);

  always_ff @(posedge clk) begin
    if (rst)                  ofs_q <= '0;
    else if (bus_we && ofs_sel) ofs_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) begin
      if (ofs_sel)       bus_rdata <= ofs_q;
      else if (data_sel) bus_rdata <= file_rdata;
      else               bus_rdata <= '0;
    end
  end

  sdram_cfg_file #(.NBANK(NBANK)) u_file (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_we && data_sel),
    .sel_ofs   (ofs_q),
    .wdata     (bus_wdata),
    .err_set_a (err_set_a),
    .err_set_b (err_set_b),
    .rdata     (file_rdata),
    .cfg_q     (cfg_word),
    .refr_q    (refresh_word),
    .time_q    (timing_word),
    .pwr_q     (power_word),
    .ecc_cfg_q (ecc_cfg_word),
    .ecc_irq   (ecc_irq),
    .bank_flat (bank_flat)
  );

  assign ctrl_enable = cfg_word[31];

  sdram_cfg_bank_dec #(.NBANK(NBANK)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .enable    (ctrl_enable),
    .bank_flat (bank_flat),
    .phys_addr (phys_addr),
    .hit_q     (bank_hit),
    .idx_q     (bank_idx)
  );

  // R1: a write to the select port is visible in the offset register next cycle
  p_ofs_write_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_we && ofs_sel) |=> (ofs_q == $past(bus_wdata)));

  // R1: a read of an unknown port returns zero
  p_stray_read_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !ofs_sel && !data_sel) |=> (bus_rdata == '0));

endmodule

// File: tb/test_sdram_cfg_regs.sv
`timescale 1ns/1ps
module test_sdram_cfg_regs;

  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  bus_addr;
  logic        bus_we, bus_re;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] err_set_a, err_set_b, phys_addr;
  logic        bank_hit, ctrl_enable, ecc_irq;
  logic [1:0]  bank_idx;
  logic [31:0] cfg_word, refresh_word, timing_word, power_word, ecc_cfg_word;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] bank_m [4];

  always #10 clk = ~clk;

  sdram_cfg_regs i_sdram_cfg_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_set_a(err_set_a),
    .err_set_b(err_set_b), .phys_addr(phys_addr), .bank_hit(bank_hit),
    .bank_idx(bank_idx), .ctrl_enable(ctrl_enable), .ecc_irq(ecc_irq),
    .cfg_word(cfg_word), .refresh_word(refresh_word), .timing_word(timing_word),
    .power_word(power_word), .ecc_cfg_word(ecc_cfg_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic port_wr(input logic [9:0] p, input logic [31:0] d);
    @(negedge clk);
    bus_addr = p; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic port_rd(input logic [9:0] p, output logic [31:0] d);
    @(negedge clk);
    bus_addr = p; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic reg_wr(input logic [31:0] ofs, input logic [31:0] d);
    port_wr(10'h10, ofs);
    port_wr(10'h11, d);
  endtask

  task automatic reg_rd(input logic [31:0] ofs, output logic [31:0] d);
    port_wr(10'h10, ofs);
    port_rd(10'h11, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) bank_m[i] = 32'h0;
  endtask

  // value expected after writing pat to a freshly reset file (cfg and status excluded)
  function automatic logic [31:0] exp_wr(input logic [31:0] ofs, input logic [31:0] pat);
    case (ofs)
      32'h10, 32'h98: return pat;
      32'h30: return pat & 32'h3FF80000;
      32'h34: return (pat & 32'hF8000000) | 32'h07C00000;
      32'h40, 32'h44, 32'h48, 32'h4C: return pat & 32'hFFDEE001;
      32'h80: return pat & 32'h018FC01F;
      32'h94: return pat & 32'h00F00000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [2:0] exp_bank(input logic [31:0] a, input logic en);
    for (int i = 0; i < 4; i++) begin
      logic [32:0] base, top;
      base = {1'b0, bank_m[i] & 32'hFF800000};
      top  = base + (33'h400000 << bank_m[i][19:17]);
      if (en && bank_m[i][0] && {1'b0, a} >= base && {1'b0, a} < top)
        return {1'b1, 2'(i)};
    end
    return 3'b000;
  endfunction

  task automatic probe(input logic [31:0] a, input logic en, input string req);
    logic [2:0] e;
    @(negedge clk);
    phys_addr = a;
    @(negedge clk);
    e = exp_bank(a, en);
    check(req, {29'd0, bank_hit, bank_idx}, {29'd0, e});
  endtask

  task automatic bank_wr(input int i, input logic [31:0] v);
    reg_wr(32'h40 + 32'(4 * i), v);
    bank_m[i] = v & 32'hFFDEE001;
  endtask

  task automatic sweep_banks(input logic en, input string req);
    for (int k = 0; k < 512; k++) probe(32'(k) << 20, en, req);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] b, t;
      b = bank_m[i] & 32'hFF800000;
      t = b + (32'h400000 << bank_m[i][19:17]);
      probe(b - 32'd1, en, req);
      probe(t - 32'd1, en, req);
      probe(t, en, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; bus_addr = '0; bus_we = 0; bus_re = 0; bus_wdata = '0;
    err_set_a = '0; err_set_b = '0; phys_addr = '0;
    do_reset();

    // R3: reset values
    port_rd(10'h10, d); check("R3 offset reg", d, 32'h0);
    reg_rd(32'h34, d); check("R3 power", d, 32'h07C00000);
    reg_rd(32'h30, d); check("R3 refresh", d, 32'h05F00000);
    reg_rd(32'h80, d); check("R3 timing", d, 32'h00854009);
    reg_rd(32'h20, d); check("R3 cfg", d, 32'h00800000);
    reg_rd(32'h24, d); check("R3 status", d, 32'h0);
    reg_rd(32'h98, d); check("R3 ecc err", d, 32'h0);
    check("R11 outputs", {31'd0, ctrl_enable}, 32'h0);
    check("R11 timing_word", timing_word, 32'h00854009);
    check("R11 power_word", power_word, 32'h07C00000);
    check("R7 irq reset", {31'd0, ecc_irq}, 32'h0);

    // R2 R6 R8: sweep every offset byte with two patterns
    for (int p = 0; p < 2; p++) begin
      logic [31:0] pat;
      pat = (p == 0) ? 32'hFFFFFFFF : 32'h5A3C96E1;
      for (int o = 0; o < 256; o++) begin
        if (o == 32'h20 || o == 32'h24) continue;
        reg_wr(32'(o), pat);
        reg_rd(32'(o), d);
        check("R2/R6/R8 write-read sweep", d, exp_wr(32'(o), pat));
      end
      check("R7 irq after sweep", {31'd0, ecc_irq}, 32'h1);
      check("R11 refresh_word", refresh_word, pat & 32'h3FF80000);
      check("R11 ecc_cfg_word", ecc_cfg_word, pat & 32'h00F00000);
    end

    // R1: other port: reads zero, write ignored
    port_wr(10'h10, 32'h80);
    port_wr(10'h12, 32'h30);
    port_rd(10'h10, d); check("R1 stray write", d, 32'h80);
    port_rd(10'h13, d); check("R1 stray read", d, 32'h0);
    port_rd(10'h11, d); check("R1 data port", d, 32'h5A3C96E1 & 32'h018FC01F);

    // R7: interrupt falls and rises
    reg_wr(32'h98, 32'h0);
    @(negedge clk); check("R7 irq fall", {31'd0, ecc_irq}, 32'h0);
    reg_wr(32'h98, 32'h00000100);
    @(negedge clk); check("R7 irq rise", {31'd0, ecc_irq}, 32'h1);

    // R4: hardware set, write-one-to-clear, set priority
    @(negedge clk); err_set_a = 32'hA5A50F0F; err_set_b = 32'h00000003;
    @(negedge clk); err_set_a = '0; err_set_b = '0;
    reg_rd(32'h00, d); check("R4 set A", d, 32'hA5A50F0F);
    reg_wr(32'h00, 32'h00000F00);
    reg_rd(32'h00, d); check("R4 clear A", d, 32'hA5A5000F);
    port_wr(10'h10, 32'h08);
    @(negedge clk);
    bus_addr = 10'h11; bus_wdata = 32'h3; bus_we = 1'b1; err_set_b = 32'h1;
    @(negedge clk);
    bus_we = 1'b0; err_set_b = '0;
    reg_rd(32'h08, d); check("R4 set wins", d, 32'h1);

    // R5: status transitions and read-only behaviour
    reg_wr(32'h20, 32'h80000000);
    reg_rd(32'h24, d); check("R5 enable", d, 32'h0);
    check("R11 ctrl_enable", {31'd0, ctrl_enable}, 32'h1);
    reg_wr(32'h20, 32'h0);
    reg_rd(32'h24, d); check("R5 disable", d, 32'h80000000);
    reg_wr(32'h20, 32'h40000000);
    reg_rd(32'h24, d); check("R5 bit30 follows", d, 32'hC0000000);
    reg_wr(32'h24, 32'h0);
    reg_rd(32'h24, d); check("R5 read-only", d, 32'hC0000000);
    reg_wr(32'h20, 32'hC0000000);
    reg_rd(32'h24, d); check("R5 re-enable", d, 32'h40000000);
    check("R11 cfg_word", cfg_word, 32'hC0000000);

    // R9 R10: bank decode
    do_reset();
    bank_wr(0, 32'h00000001);
    bank_wr(1, 32'h00840001);
    bank_wr(2, 32'h100C0001);
    bank_wr(3, 32'h00880001);
    sweep_banks(1'b0, "R10 disabled");
    reg_wr(32'h20, 32'h80000000);
    sweep_banks(1'b1, "R9/R10 enabled");
    bank_wr(1, 32'h00840000);
    sweep_banks(1'b1, "R10 bank1 invalid");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule